// File: doc/BRIEF.md
# Frame-Alternating Sweep Clock Divider

This block takes a master clock and produces a sweep clock at half its rate. A toggle stage halves the master clock. A second toggle stage keeps a one-bit frame parity, and that parity selects which polarity of the halved clock reaches the output. Because the parity changes once per display frame, the sweep clock's phase jumps by 180 degrees at every frame boundary. Over a pair of frames, the downstream modulation lands on points halfway between those of the frame before.

The frame boundary comes from an active-low vertical drive pulse that arrives once per frame during retrace. The pulse is synchronised into the master clock domain. Its trailing (low-to-high) edge becomes a single-cycle event, and that event toggles the parity. The output is selected in AND-OR form from the next-state values of both stages, then registered, so the output pin is driven straight from a flip-flop.

Top module: `frame_phase_sweep`

## Requirements
- R1: While `rst_n` is low, `sweep_o` and `frame_par_o` are both 0. Asserting `rst_n` clears both without waiting for a clock edge.
- R2: Within a frame, `sweep_o` changes value on every rising edge of `clk`, so its period is two master clock cycles.
- R3: `frame_par_o` toggles exactly once for each low-to-high transition of `vdrive_n`, including a pulse that is low for only one clock cycle. A falling edge of `vdrive_n`, or holding it at a steady level, leaves `frame_par_o` unchanged.
- R4: With the default two synchroniser stages, a rise of `vdrive_n` set up before a clock edge shows on `frame_par_o` after the third rising edge. It is not visible after the second.
- R5: On the clock edge where `frame_par_o` changes, `sweep_o` keeps its previous value for one extra cycle. This is the 180-degree phase step. On every other edge, R2 holds.
- R6: When frames have the same even length in clock cycles, `sweep_o` sampled a fixed number of cycles after each parity change has the opposite value in consecutive frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| vdrive_n | input | 1 | Active-low vertical drive, one pulse per frame, asynchronous to `clk` |
| sweep_o | output | 1 | Registered half-rate sweep clock, phase-reversed on alternate frames |
| frame_par_o | output | 1 | Current frame parity (0 = direct polarity, 1 = inverted polarity) |

## Verification
The divider is driven with no frame pulses at all, to show a clean two-cycle period with no parity effect. It is then driven with frames of odd, even and mixed lengths. In those runs, every cycle is classed as either a toggle or a hold, and each class must match whether the parity moved on that edge. Equal even-length frames are used to show that the phase is inverted rather than just shifted: without the reversal, the sample at a fixed offset would repeat. Vertical drive patterns with a long low level, a one-cycle pulse and a precisely timed rising edge separate the trailing-edge trigger from level or leading-edge triggering, and pin down the synchroniser latency.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  // Default depth of the synchronisers for reset release and vertical drive
  parameter int unsigned DEF_SYNC_STAGES = 2;
  parameter int unsigned DEF_RST_STAGES  = 2;

  // Frame parity: which polarity of the halved clock drives the output
  typedef enum logic {
    PHASE_DIRECT   = 1'b0,
    PHASE_INVERTED = 1'b1
  } frame_phase_e;

endpackage

// File: rtl/sweep_sync.sv
module sweep_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_chain
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RESET_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sweep_toggle.sv
module sweep_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic q,
  output logic q_next
);

  always_comb begin
    q_next = q;
    if (en) begin
      q_next = ~q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_next;
    end
  end

endmodule

// File: rtl/sweep_out_sel.sv
module sweep_out_sel
  import sweep_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         half_next,
  input  frame_phase_e phase_next,
  output logic         sweep_q
);

  logic pass_direct;
  logic pass_inverted;
  logic sweep_d;

  always_comb begin
    pass_direct   = half_next  & (phase_next == PHASE_DIRECT);
    pass_inverted = ~half_next & (phase_next == PHASE_INVERTED);
    sweep_d       = pass_direct | pass_inverted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_q <= 1'b0;
    end else begin
      sweep_q <= sweep_d;
    end
  end

endmodule

// File: rtl/frame_phase_sweep.sv
module frame_phase_sweep
  import sweep_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned RST_STAGES  = DEF_RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vdrive_n,
  output logic sweep_o,
  output logic frame_par_o
);

  logic         rst_sync_n;
  logic         vd_sync;
  logic         vd_prev_q;
  logic         vd_prev_d;
  logic         vd_rise;
  logic         half_q;
  logic         half_next;
  logic         par_q;
  logic         par_next;
  frame_phase_e phase_next;

  // Reset asserts at once and is released on a clock edge
  sweep_sync #(
    .STAGES    (RST_STAGES),
    .RESET_VAL (1'b0)
  ) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  // Vertical drive into the clk domain; it idles high, so it resets high
  sweep_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_vd_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (vdrive_n),
    .q     (vd_sync)
  );

  always_comb begin
    vd_prev_d = vd_sync;
    vd_rise   = vd_sync & ~vd_prev_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vd_prev_q <= 1'b1;
    end else begin
      vd_prev_q <= vd_prev_d;
    end
  end

  // Half-rate stage: enabled on every cycle
  sweep_toggle u_half (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (1'b1),
    .q      (half_q),
    .q_next (half_next)
  );

  // Frame parity stage: enabled on the trailing edge of vertical drive
  sweep_toggle u_parity (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (vd_rise),
    .q      (par_q),
    .q_next (par_next)
  );

  assign phase_next = frame_phase_e'(par_next);

  sweep_out_sel u_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .half_next  (half_next),
    .phase_next (phase_next),
    .sweep_q    (sweep_o)
  );

  assign frame_par_o = par_q;

  logic unused_half;
  assign unused_half = half_q;

endmodule

// File: rtl/frame_phase_sweep_chk.sv
module frame_phase_sweep_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_sync_n,
  input logic vd_rise,
  input logic sweep_o,
  input logic frame_par_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!sweep_o && !frame_par_o));

  // R2
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $stable(frame_par_o)) |-> (sweep_o != $past(sweep_o)));

  // R3
  parity_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_par_o != $past(frame_par_o)) |-> $past(vd_rise));

  // R3
  parity_event_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vd_rise |=> (frame_par_o != $past(frame_par_o)));

  // R5
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && !$stable(frame_par_o)) |-> $stable(sweep_o));

endmodule

bind frame_phase_sweep frame_phase_sweep_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_sync_n  (rst_sync_n),
  .vd_rise     (vd_rise),
  .sweep_o     (sweep_o),
  .frame_par_o (frame_par_o)
);

// File: tb/frame_phase_sweep_tb.sv
module frame_phase_sweep_tb;

  logic clk;
  logic rst_n;
  logic vdrive_n;
  logic sweep_o;
  logic frame_par_o;

  int n_checks;
  int n_fails;
  bit done;

  frame_phase_sweep u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .vdrive_n    (vdrive_n),
    .sweep_o     (sweep_o),
    .frame_par_o (frame_par_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    vdrive_n = 1'b1;
    repeat (4) tick();
    check(sweep_o == 1'b0, "R1 sweep in reset", sweep_o, 0);
    check(frame_par_o == 1'b0, "R1 parity in reset", frame_par_o, 0);
    rst_n = 1'b1;
    repeat (5) tick();
  endtask

  // R2: no frame pulses, output alternates every cycle
  task automatic t_free_run();
    logic prev;
    int bad;
    bad  = 0;
    prev = sweep_o;
    for (int i = 0; i < 24; i++) begin
      tick();
      if (sweep_o == prev) bad++;
      prev = sweep_o;
    end
    check(bad == 0, "R2 toggle every cycle", bad, 0);
    check(frame_par_o == 1'b0, "R2 parity idle", frame_par_o, 0);
  endtask

  // R4: trailing edge reaches parity after third clock edge
  task automatic t_latency();
    logic p0;
    p0 = frame_par_o;
    vdrive_n = 1'b0;
    repeat (4) tick();
    check(frame_par_o == p0, "R3 falling edge ignored", frame_par_o, p0);
    vdrive_n = 1'b1;
    tick();
    tick();
    check(frame_par_o == p0, "R4 not after second edge", frame_par_o, p0);
    tick();
    check(frame_par_o == !p0, "R4 changed after third edge", frame_par_o, !p0);
    repeat (4) tick();
  endtask

  // R3: long low level, then single trailing edge
  task automatic t_fall_level();
    logic p0;
    p0 = frame_par_o;
    vdrive_n = 1'b0;
    repeat (12) tick();
    check(frame_par_o == p0, "R3 low level ignored", frame_par_o, p0);
    vdrive_n = 1'b1;
    repeat (5) tick();
    check(frame_par_o == !p0, "R3 one toggle on rise", frame_par_o, !p0);
    repeat (10) tick();
    check(frame_par_o == !p0, "R3 high level ignored", frame_par_o, !p0);
  endtask

  // R3: one-cycle pulse still counted exactly once
  task automatic t_short_pulse();
    logic p0;
    p0 = frame_par_o;
    vdrive_n = 1'b0;
    tick();
    vdrive_n = 1'b1;
    repeat (6) tick();
    check(frame_par_o == !p0, "R3 short pulse", frame_par_o, !p0);
  endtask

  // R5 and R2 across frames of mixed length
  task automatic t_frame_hold();
    logic ps;
    logic pp;
    int lens[4];
    int holds;
    lens = '{13, 20, 31, 8};
    holds = 0;
    ps = sweep_o;
    pp = frame_par_o;
    foreach (lens[f]) begin
      for (int c = 0; c < lens[f]; c++) begin
        vdrive_n = (c < 2) ? 1'b0 : 1'b1;
        tick();
        if (frame_par_o != pp) begin
          holds++;
          check(sweep_o == ps, "R5 hold at parity change", sweep_o, ps);
        end else begin
          check(sweep_o != ps, "R2 toggle inside frame", sweep_o, !ps);
        end
        ps = sweep_o;
        pp = frame_par_o;
      end
    end
    vdrive_n = 1'b1;
    repeat (6) tick();
    check(holds == 4, "R5 one step per frame", holds, 4);
  endtask

  // R6: equal even frames, fixed offset gives opposite values
  task automatic t_phase_offset();
    logic pp;
    logic last;
    int off;
    int seen;
    pp   = frame_par_o;
    off  = -1;
    seen = 0;
    last = 1'b0;
    for (int f = 0; f < 6; f++) begin
      for (int c = 0; c < 40; c++) begin
        vdrive_n = (c < 3) ? 1'b0 : 1'b1;
        tick();
        if (frame_par_o != pp) off = 0;
        else if (off >= 0) off++;
        pp = frame_par_o;
        if (off == 7) begin
          if (seen > 0) check(sweep_o == !last, "R6 inverted per frame", sweep_o, !last);
          last = sweep_o;
          seen++;
        end
      end
    end
    vdrive_n = 1'b1;
    check(seen >= 5, "R6 offsets sampled", seen, 5);
  endtask

  // R1: asynchronous clear mid-run
  task automatic t_async_reset();
    if (frame_par_o == 1'b0) t_short_pulse();
    check(frame_par_o == 1'b1, "R1 parity set before reset", frame_par_o, 1);
    #2;
    rst_n = 1'b0;
    #1;
    check(sweep_o == 1'b0, "R1 async sweep clear", sweep_o, 0);
    check(frame_par_o == 1'b0, "R1 async parity clear", frame_par_o, 0);
    @(negedge clk);
    do_reset();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    vdrive_n = 1'b1;
    @(negedge clk);
    do_reset();
    t_free_run();
    t_latency();
    t_fall_level();
    t_short_pulse();
    t_frame_hold();
    t_phase_offset();
    t_async_reset();
    t_free_run();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

endmodule